// File: doc/BRIEF.md
# Blank-Gated Timer Bank

This block holds six free-running timers that a host programs through a small register port and that raise active-low interrupt requests. Timers 0 to 2 are 16 bits wide and timers 3 to 5 are 32 bits wide. Each timer either counts every clock cycle or counts on an alternate tick, and an optional gate ties its counting to the video blanking signals. The gate can allow counting only during or only outside blanking, clear the count on blanking edges, or hold the timer until the end of the next blanking interval.

The blanking source depends on the index. Horizontal blanking gates timer 0. Vertical blanking gates timers 1 and 3. Timers 2, 4 and 5 have no blanking source, so on those timers the gate only turns counting on or off. Blanking edges are found by comparing each level with its value one cycle earlier. Every write takes effect at the next clock edge. Reads are combinational. The register port is plain control: it has no stream and no back-pressure, and a write is accepted on every cycle in which `wr_en` is high.

Top module: `gated_timer_bank`

## Requirements
- R1: A timer wraps to zero after its all-ones value: after 0xFFFF for timers 0 to 2 and after 0xFFFFFFFF for timers 3 to 5. A write to count (`wr_reg` 0) loads the value, truncated to the timer's width.
- R2: With gating on (mode bit 0 = 1) and gate mode 0 (mode bits 2:1 = 0), a timer counts only while its blank level is low. Timer 0 uses `hblank`. Timers 1 and 3 use `vblank`.
- R3: Gate mode 1 counts on every tick and clears the count in the cycle after the blank level falls.
- R4: Gate mode 2 counts only while the blank level is high, and clears the count when the blank level rises and when it falls.
- R5: Gate mode 3, after a mode write, holds the count until the blank level next falls. At that edge the count is cleared once. After that the timer counts freely, with no further clears or stops.
- R6: On timers 2, 4 and 5 with gating on, the timer counts only when gate mode bit 0 is 1. Gate modes 0 and 2 stop it.
- R7: With the alternate-source bit (mode bit 8) set, timer 0 advances only on cycles where `pix_en` is high, and timers 1 and 3 advance once for each rising edge of `hblank`. The bit has no effect on timers 2, 4 and 5.
- R8: A mode write (`wr_reg` 1, bits 8:0) resets the count to zero, drives the timer's `irq_n` high and re-arms the timer's interrupt.
- R9: A count read of a gated timer in gate mode 2 returns zero whenever that timer is not counting.
- R10: Mode bit 4 enables a target interrupt and mode bit 5 enables an overflow interrupt. A target event is an increment whose new value equals the target (`wr_reg` 2). An overflow event is an increment from the all-ones value. An enabled event drives `irq_n` low. When mode bit 7 (toggle) is set, the event inverts `irq_n` instead. Unless mode bit 6 (repeat) is set, only the first event after a re-arm acts. A target write drives `irq_n` high and re-arms the interrupt.
- R11: When a gate clear and an increment fall in the same cycle, the count becomes zero. A count write in the same cycle overrides both, and no interrupt event comes from a timer in a cycle in which it is written.
- R12: With mode bit 3 set, an increment that reaches the target loads zero in place of the target value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hblank | input | 1 | Horizontal blanking level |
| vblank | input | 1 | Vertical blanking level |
| pix_en | input | 1 | Pixel-rate tick for timer 0 when it uses the alternate source |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Timer index for the write |
| wr_reg | input | 2 | Register to write: 0 count, 1 mode, 2 target |
| wr_data | input | 32 | Write data |
| rd_idx | input | 3 | Timer index for the read |
| rd_reg | input | 2 | Register to read: 0 count, 1 mode, 2 target |
| rd_data | output | 32 | Combinational read data, zero-extended |
| irq_n | output | 6 | Interrupt request per timer, active low |

## Verification
The assertions check, on every cycle, that a mode write leaves the count at zero, that a target write leaves `irq_n` high, and that a held gate-mode-3 timer keeps its count until the one clear at its release. They also check that the even gate modes freeze timers 2, 4 and 5, and that a count read of a gate-mode-2 timer returns zero while that timer is idle. Other behaviours only show up in the bench scenarios that compare against a reference model: the exact cycle of a wrap, the ordering of clear against increment, the alternate ticks, and the one-shot, repeat and toggle interrupt sequences.

// File: rtl/gtm_pkg.sv
package gtm_pkg;

  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_MODE   = 2'd1,
    SEL_TARGET = 2'd2
  } reg_sel_e;

  typedef enum logic [1:0] {
    SRC_HBLANK = 2'd0,
    SRC_VBLANK = 2'd1,
    SRC_NONE   = 2'd2
  } gate_src_e;

  typedef struct packed {
    logic       alt_src;     // bit 8
    logic       irq_toggle;  // bit 7
    logic       irq_repeat;  // bit 6
    logic       irq_on_ovf;  // bit 5
    logic       irq_on_tgt;  // bit 4
    logic       zero_on_tgt; // bit 3
    logic [1:0] gate_mode;   // bits 2:1
    logic       gate_en;     // bit 0
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  // Blank source wired to each timer position
  function automatic gate_src_e src_of(input int idx);
    case (idx)
      0:       return SRC_HBLANK;
      1, 3:    return SRC_VBLANK;
      default: return SRC_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gtm_blank_edges.sv
module gtm_blank_edges #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/gtm_gate_ctrl.sv
module gtm_gate_ctrl
  import gtm_pkg::*;
#(
  parameter gate_src_e SRC = SRC_NONE
) (
  input  mode_t mode,
  input  logic  hold,
  input  logic  blank,
  input  logic  blank_rise,
  input  logic  blank_fall,
  input  logic  alt_tick,
  output logic  inc_req,
  output logic  clr,
  output logic  release_hold,
  output logic  read_zero
);
  logic run;
  logic tick;
  logic sourced;

  assign sourced = mode.gate_en && (SRC != SRC_NONE);
  assign tick    = mode.alt_src ? alt_tick : 1'b1;

  always_comb begin
    if (!mode.gate_en)        run = 1'b1;
    else if (SRC == SRC_NONE) run = mode.gate_mode[0];
    else begin
      case (mode.gate_mode)
        2'd0:    run = !blank;
        2'd1:    run = 1'b1;
        2'd2:    run = blank;
        default: run = !hold;
      endcase
    end
  end

  always_comb begin
    clr          = 1'b0;
    release_hold = 1'b0;
    if (sourced) begin
      case (mode.gate_mode)
        2'd1: clr = blank_fall;
        2'd2: clr = blank_rise | blank_fall;
        2'd3: begin
          release_hold = hold && blank_fall;
          clr          = hold && blank_fall;
        end
        default: ;
      endcase
    end
  end

  assign inc_req   = tick && run;
  assign read_zero = mode.gate_en && (mode.gate_mode == 2'd2) && !run;
endmodule

// File: rtl/gtm_timer_core.sv
module gtm_timer_core
  import gtm_pkg::*;
#(
  parameter int W       = 16,
  parameter bit HAS_SRC = 1'b1,
  parameter int OUT_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_count,
  input  logic             wr_mode,
  input  logic             wr_target,
  input  logic [W-1:0]     wr_data,
  input  logic             inc_req,
  input  logic             clr,
  input  logic             release_hold,
  output mode_t            mode_o,
  output logic             hold_o,
  output logic [OUT_W-1:0] count_o,
  output logic [OUT_W-1:0] target_o,
  output logic             irq_n_o
);
  mode_t        mode_q;
  mode_t        mode_wr;
  logic [W-1:0] count_q;
  logic [W-1:0] target_q;
  logic [W-1:0] count_inc;
  logic         irq_q;
  logic         armed_q;
  logic         hold_q;
  logic         wr_any;
  logic         inc_eff;
  logic         hit_tgt;
  logic         hit_ovf;
  logic         fire;

  assign mode_wr   = mode_t'(wr_data[MODE_W-1:0]);
  assign wr_any    = wr_count | wr_mode | wr_target;
  assign inc_eff   = inc_req && !clr && !wr_count;
  assign count_inc = count_q + W'(1);
  assign hit_tgt   = inc_eff && (count_inc == target_q);
  assign hit_ovf   = inc_eff && (&count_q);
  assign fire      = armed_q && !wr_any &&
                     ((hit_tgt && mode_q.irq_on_tgt) || (hit_ovf && mode_q.irq_on_ovf));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      count_q  <= '0;
      target_q <= '0;
      irq_q    <= 1'b1;
      armed_q  <= 1'b1;
      hold_q   <= 1'b0;
    end else if (wr_mode) begin
      mode_q  <= mode_wr;
      count_q <= '0;
      irq_q   <= 1'b1;
      armed_q <= 1'b1;
      hold_q  <= HAS_SRC && mode_wr.gate_en && (mode_wr.gate_mode == 2'd3);
    end else begin
      if (wr_count)     count_q <= wr_data;
      else if (clr)     count_q <= '0;
      else if (inc_eff) count_q <= (hit_tgt && mode_q.zero_on_tgt) ? '0 : count_inc;
      if (release_hold) hold_q <= 1'b0;
      if (wr_target) begin
        target_q <= wr_data;
        irq_q    <= 1'b1;
        armed_q  <= 1'b1;
      end else if (fire) begin
        irq_q   <= mode_q.irq_toggle ? ~irq_q : 1'b0;
        armed_q <= mode_q.irq_repeat;
      end
    end
  end

  assign mode_o   = mode_q;
  assign hold_o   = hold_q;
  assign count_o  = OUT_W'(count_q);
  assign target_o = OUT_W'(target_q);
  assign irq_n_o  = irq_q;
endmodule

// File: rtl/gated_timer_bank.sv
module gated_timer_bank
  import gtm_pkg::*;
#(
  parameter int  NUM_TIMERS = 6,
  parameter int  NARROW_CNT = 3,
  parameter int  NARROW_W   = 16,
  parameter int  WIDE_W     = 32,
  localparam int IDX_W      = $clog2(NUM_TIMERS),
  localparam int DATA_W     = WIDE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hblank,
  input  logic                  vblank,
  input  logic                  pix_en,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [1:0]            wr_reg,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [IDX_W-1:0]      rd_idx,
  input  logic [1:0]            rd_reg,
  output logic [DATA_W-1:0]     rd_data,
  output logic [NUM_TIMERS-1:0] irq_n
);
  logic [1:0] blank_rise;
  logic [1:0] blank_fall;

  logic [NUM_TIMERS-1:0][DATA_W-1:0] cnt_all;
  logic [NUM_TIMERS-1:0][DATA_W-1:0] tgt_all;
  logic [NUM_TIMERS-1:0][MODE_W-1:0] mode_all;
  logic [NUM_TIMERS-1:0]             hold_all;
  logic [NUM_TIMERS-1:0]             rzero_all;

  // bit 0 horizontal, bit 1 vertical
  gtm_blank_edges #(.N(2)) u_edges (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  ({vblank, hblank}),
    .rise (blank_rise),
    .fall (blank_fall)
  );

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
    localparam gate_src_e SRC = src_of(i);
    localparam int        W   = (i < NARROW_CNT) ? NARROW_W : WIDE_W;

    mode_t mode_i;
    logic  hit_i, inc_i, clr_i, rel_i;
    logic  blank_i, rise_i, fall_i, alt_i;

    assign hit_i   = wr_en && (wr_idx == IDX_W'(i));
    assign blank_i = (SRC == SRC_HBLANK) ? hblank        : vblank;
    assign rise_i  = (SRC == SRC_HBLANK) ? blank_rise[0] : blank_rise[1];
    assign fall_i  = (SRC == SRC_HBLANK) ? blank_fall[0] : blank_fall[1];
    assign alt_i   = (SRC == SRC_HBLANK) ? pix_en :
                     (SRC == SRC_VBLANK) ? blank_rise[0] : 1'b1;

    gtm_gate_ctrl #(.SRC(SRC)) u_gate (
      .mode        (mode_i),
      .hold        (hold_all[i]),
      .blank       (blank_i),
      .blank_rise  (rise_i),
      .blank_fall  (fall_i),
      .alt_tick    (alt_i),
      .inc_req     (inc_i),
      .clr         (clr_i),
      .release_hold(rel_i),
      .read_zero   (rzero_all[i])
    );

    gtm_timer_core #(
      .W      (W),
      .HAS_SRC(SRC != SRC_NONE),
      .OUT_W  (DATA_W)
    ) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_count    (hit_i && (wr_reg == SEL_COUNT)),
      .wr_mode     (hit_i && (wr_reg == SEL_MODE)),
      .wr_target   (hit_i && (wr_reg == SEL_TARGET)),
      .wr_data     (wr_data[W-1:0]),
      .inc_req     (inc_i),
      .clr         (clr_i),
      .release_hold(rel_i),
      .mode_o      (mode_i),
      .hold_o      (hold_all[i]),
      .count_o     (cnt_all[i]),
      .target_o    (tgt_all[i]),
      .irq_n_o     (irq_n[i])
    );

    assign mode_all[i] = mode_i;
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_TIMERS; k++) begin
      if (rd_idx == IDX_W'(k)) begin
        case (rd_reg)
          SEL_COUNT:  rd_data = rzero_all[k] ? '0 : cnt_all[k];
          SEL_MODE:   rd_data = DATA_W'(mode_all[k]);
          SEL_TARGET: rd_data = tgt_all[k];
          default:    rd_data = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/gtm_checker.sv
module gtm_checker
  import gtm_pkg::*;
#(
  parameter int NUM_TIMERS = 6,
  parameter int IDX_W      = 3,
  parameter int DATA_W     = 32
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              hblank,
  input logic                              vblank,
  input logic                              wr_en,
  input logic [IDX_W-1:0]                  wr_idx,
  input logic [1:0]                        wr_reg,
  input logic [IDX_W-1:0]                  rd_idx,
  input logic [1:0]                        rd_reg,
  input logic [DATA_W-1:0]                 rd_data,
  input logic [NUM_TIMERS-1:0]             irq_n,
  input logic [NUM_TIMERS-1:0][DATA_W-1:0] cnt_all,
  input logic [NUM_TIMERS-1:0][MODE_W-1:0] mode_all,
  input logic [NUM_TIMERS-1:0]             hold_all
);
  mode_t sel_mode;
  logic  sel_valid;
  logic  sel_idle_blank;

  always_comb begin
    sel_mode       = '0;
    sel_valid      = 1'b0;
    sel_idle_blank = 1'b0;
    for (int k = 0; k < NUM_TIMERS; k++) begin
      if (rd_idx == IDX_W'(k)) begin
        sel_mode  = mode_t'(mode_all[k]);
        sel_valid = 1'b1;
        case (src_of(k))
          SRC_HBLANK: sel_idle_blank = !hblank;
          SRC_VBLANK: sel_idle_blank = !vblank;
          default:    sel_idle_blank = 1'b1;
        endcase
      end
    end
  end

  AST_GM2_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && rd_reg == SEL_COUNT && sel_mode.gate_en && sel_mode.gate_mode == 2'd2 && sel_idle_blank)
    |-> rd_data == '0); // R9

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chk
    AST_MODE_WRITE_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(i) && wr_reg == SEL_MODE) |=> cnt_all[i] == '0); // R8

    AST_TARGET_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(i) && wr_reg == SEL_TARGET) |=> irq_n[i]); // R10

    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_all[i] && !(wr_en && wr_idx == IDX_W'(i)))
      |=> (cnt_all[i] == $past(cnt_all[i])) || (cnt_all[i] == '0)); // R5

    if (src_of(i) == SRC_NONE) begin : g_fixed
      AST_EVEN_GATE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_all[i][0] && !mode_all[i][1] && !(wr_en && wr_idx == IDX_W'(i)))
        |=> $stable(cnt_all[i])); // R6
    end
  end
endmodule

bind gated_timer_bank gtm_checker #(
  .NUM_TIMERS(NUM_TIMERS),
  .IDX_W     (IDX_W),
  .DATA_W    (DATA_W)
) u_gtm_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .hblank  (hblank),
  .vblank  (vblank),
  .wr_en   (wr_en),
  .wr_idx  (wr_idx),
  .wr_reg  (wr_reg),
  .rd_idx  (rd_idx),
  .rd_reg  (rd_reg),
  .rd_data (rd_data),
  .irq_n   (irq_n),
  .cnt_all (cnt_all),
  .mode_all(mode_all),
  .hold_all(hold_all)
);

// File: tb/gated_timer_bank_test.sv
`timescale 1ns/1ps
module gated_timer_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hblank = 1'b0, vblank = 1'b0, pix_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [1:0]  wr_reg = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_idx = '0;
  logic [1:0]  rd_reg = '0;
  logic [31:0] rd_data;
  logic [5:0]  irq_n;

  int nvec = 0, nfail = 0;
  bit done = 1'b0;
  int hc = 0, vc = 0;

  logic        p_en = 1'b0;
  logic [2:0]  p_idx = '0;
  logic [1:0]  p_reg = '0;
  logic [31:0] p_data = '0;

  // reference state
  logic [31:0] m_cnt [6];
  logic [31:0] m_tgt [6];
  logic [8:0]  m_mode [6];
  logic        m_irq [6];
  logic        m_arm [6];
  logic        m_hold [6];
  logic        m_hb, m_vb;

  always #2 clk = ~clk;

  gated_timer_bank uut (
    .clk(clk), .rst_n(rst_n), .hblank(hblank), .vblank(vblank), .pix_en(pix_en),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_reg(wr_reg), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_reg(rd_reg), .rd_data(rd_data), .irq_n(irq_n)
  );

  // 0 horizontal source, 1 vertical source, 2 none
  function automatic int src_b(input int i);
    if (i == 0) return 0;
    if (i == 1 || i == 3) return 1;
    return 2;
  endfunction

  function automatic logic [31:0] wmask(input int i);
    return (i < 3) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic runs(input int i);
    logic bl;
    logic [1:0] gm;
    bl = (src_b(i) == 0) ? hblank : vblank;
    gm = m_mode[i][2:1];
    if (!m_mode[i][0]) return 1'b1;
    if (src_b(i) == 2) return gm[0];
    case (gm)
      2'd0: return !bl;
      2'd1: return 1'b1;
      2'd2: return bl;
      default: return !m_hold[i];
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input int i, input int r);
    if (i > 5) return 32'd0;
    case (r)
      0: return (m_mode[i][0] && m_mode[i][2:1] == 2'd2 && !runs(i)) ? 32'd0 : m_cnt[i];
      1: return {23'd0, m_mode[i]};
      2: return m_tgt[i];
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [5:0] exp_irq();
    logic [5:0] v;
    for (int i = 0; i < 6; i++) v[i] = m_irq[i];
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) begin
        m_cnt[i] = 0; m_tgt[i] = 0; m_mode[i] = 0;
        m_irq[i] = 1; m_arm[i] = 1; m_hold[i] = 0;
      end
      m_hb = 0; m_vb = 0;
    end else begin
      logic hs, he, vs, ve;
      hs = hblank && !m_hb; he = !hblank && m_hb;
      vs = vblank && !m_vb; ve = !vblank && m_vb;
      for (int i = 0; i < 6; i++) begin
        int s;
        logic bs, be, tick, run, clr, rel, mine, inc, ht, ho, fire;
        logic [1:0] gm;
        logic [31:0] msk, nxt;
        s = src_b(i);
        gm = m_mode[i][2:1];
        bs = (s == 0) ? hs : vs;
        be = (s == 0) ? he : ve;
        tick = !m_mode[i][8] ? 1'b1 : (s == 0 ? pix_en : (s == 1 ? hs : 1'b1));
        run = runs(i);
        clr = 0; rel = 0;
        if (m_mode[i][0] && s != 2) begin
          if (gm == 2'd1) clr = be;
          if (gm == 2'd2) clr = bs | be;
          if (gm == 2'd3) begin rel = m_hold[i] && be; clr = rel; end
        end
        mine = wr_en && (int'(wr_idx) == i);
        msk = wmask(i);
        if (mine && wr_reg == 2'd1) begin
          m_mode[i] = wr_data[8:0];
          m_cnt[i] = 0; m_irq[i] = 1; m_arm[i] = 1;
          m_hold[i] = wr_data[0] && wr_data[2:1] == 2'd3 && s != 2;
        end else begin
          inc = tick && run && !clr && !(mine && wr_reg == 2'd0);
          nxt = (m_cnt[i] + 1) & msk;
          ht = inc && (nxt == m_tgt[i]);
          ho = inc && (m_cnt[i] == msk);
          fire = m_arm[i] && !mine && ((ht && m_mode[i][4]) || (ho && m_mode[i][5]));
          if (mine && wr_reg == 2'd0) m_cnt[i] = wr_data & msk;
          else if (clr) m_cnt[i] = 0;
          else if (inc) m_cnt[i] = (ht && m_mode[i][3]) ? 32'd0 : nxt;
          if (rel) m_hold[i] = 0;
          if (mine && wr_reg == 2'd2) begin
            m_tgt[i] = wr_data & msk; m_irq[i] = 1; m_arm[i] = 1;
          end else if (fire) begin
            m_irq[i] = m_mode[i][7] ? !m_irq[i] : 1'b0;
            m_arm[i] = m_mode[i][6];
          end
        end
      end
      m_hb = hblank; m_vb = vblank;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic cycle(input string req, input int ri, input int rr);
    @(negedge clk);
    rd_idx = 3'(ri); rd_reg = 2'(rr);
    #1;
    chk(req, "read", rd_data, exp_read(ri, rr));
    chk("R10", "irq_n", {26'd0, irq_n}, {26'd0, exp_irq()});
    wr_en = p_en; wr_idx = p_idx; wr_reg = p_reg; wr_data = p_data;
    p_en = 1'b0;
    hc = (hc + 1) % 10;
    vc = (vc + 1) % 70;
    hblank = (hc >= 7);
    vblank = (vc >= 62);
    pix_en = ($urandom % 3) == 0;
  endtask

  task automatic run_n(input int n, input string req, input int ri, input int rr);
    for (int k = 0; k < n; k++) cycle(req, ri, rr);
  endtask

  task automatic wr(input int i, input int r, input logic [31:0] d, input string req);
    p_en = 1'b1; p_idx = 3'(i); p_reg = 2'(r); p_data = d;
    cycle(req, i, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    #1;
    chk("R8", "reset irq_n", {26'd0, irq_n}, 32'h3F);
    for (int i = 0; i < 6; i++) cycle("R8", i, 0);

    // R1 wrap points
    wr(0, 0, 32'h0000_FFFD, "R1");
    run_n(5, "R1", 0, 0);
    wr(3, 0, 32'hFFFF_FFFD, "R1");
    run_n(5, "R1", 3, 0);
    wr(2, 0, 32'h0012_FFFE, "R1");
    run_n(4, "R1", 2, 0);

    // R2 count outside blanking
    wr(0, 1, 32'h001, "R2"); run_n(25, "R2", 0, 0);
    wr(1, 1, 32'h001, "R2"); run_n(80, "R2", 1, 0);
    // R3 clear on blank end, R11 clear beats increment
    wr(0, 1, 32'h003, "R3"); run_n(25, "R3", 0, 0);
    wr(3, 1, 32'h003, "R11"); run_n(80, "R11", 3, 0);
    // R4 count inside blanking, R9 read zero
    wr(1, 1, 32'h005, "R4"); run_n(80, "R4", 1, 0);
    wr(0, 1, 32'h005, "R9"); run_n(25, "R9", 0, 0);
    // R5 deferred start
    wr(3, 1, 32'h007, "R5"); run_n(140, "R5", 3, 0);
    // R6 index without blank source
    wr(2, 1, 32'h001, "R6"); run_n(10, "R6", 2, 0);
    wr(4, 1, 32'h003, "R6"); run_n(10, "R6", 4, 0);
    wr(5, 1, 32'h005, "R6"); run_n(10, "R6", 5, 0);
    // R7 alternate sources
    wr(0, 1, 32'h100, "R7"); run_n(30, "R7", 0, 0);
    wr(1, 1, 32'h100, "R7"); run_n(40, "R7", 1, 0);
    wr(5, 1, 32'h100, "R7"); run_n(10, "R7", 5, 0);
    // R8 mode write clears a loaded count
    wr(2, 1, 32'h000, "R8");
    wr(2, 0, 32'h0000_0123, "R8");
    wr(2, 1, 32'h000, "R8"); run_n(3, "R8", 2, 0);
    // R10 one-shot target and overflow interrupts
    wr(2, 2, 32'd10, "R10");
    wr(2, 1, 32'h010, "R10"); run_n(30, "R10", 2, 0);
    wr(2, 2, 32'd4, "R10"); run_n(5, "R10", 2, 1);
    wr(4, 1, 32'h020, "R10");
    wr(4, 0, 32'hFFFF_FFFC, "R10"); run_n(8, "R10", 4, 0);
    // R12 clear on target with repeat toggle
    wr(5, 2, 32'd5, "R12");
    wr(5, 1, 32'h0D8, "R12"); run_n(30, "R12", 5, 0);
    cycle("R12", 5, 2);

    // random mixed traffic
    for (int n = 0; n < 5000; n++) begin
      if (($urandom % 10) == 0) begin
        int r;
        r = $urandom % 3;
        p_en = 1'b1; p_idx = 3'($urandom % 6); p_reg = 2'(r);
        if (r == 1)      p_data = $urandom % 512;
        else if (r == 0) p_data = ($urandom % 2) ? ($urandom % 40) : (32'hFFFF_FFF0 | ($urandom % 16));
        else             p_data = $urandom % 48;
      end
      cycle("R2", $urandom % 7, $urandom % 4);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule